// File: doc/BRIEF.md
# NAND page copy sequencer

This block copies a run of consecutive flash pages from one page address to another without help from a processor. For each page it sends a read command and the source page address, waits for the card, and pulls the page into a local page buffer. It then sends a data-load command with the destination address, streams the buffer back out, and confirms the program. Finally it waits for the card again and reads the status byte. After each page both page addresses move up by one and the remaining count drops by one.

Every wait on the card's ready/busy line is limited by a cycle counter. An expired wait stops the copy and raises the error flag. A status byte that reports a failure stops it the same way. A two-bit code tells the two causes apart. The host starts a run with a one-cycle pulse that carries the source page, the destination page and the page count. A run that ends cleanly gives a one-cycle done pulse.

Top module: `nand_page_copier`

## Requirements
- R1: After reset, done, error and err_code are 0, both strobes are high, and the command-latch and address-latch outputs are low.
- R2: Each page issues its commands in this order: 0x00, the source address, 0x80, the destination address, 0x10, then 0x70. The source page is read between the 0x00 address phase and 0x80, and the status byte is read after 0x70.
- R3: Each address phase sends ADDR_BYTES bytes of the page address, least significant byte first. The address-latch output is high during these bytes and the command-latch output is low.
- R4: Each pass reads PAGE_BYTES bytes from the card into the page buffer and writes the same bytes back, in the same order, after 0x80.
- R5: A low ready/busy line means busy. Three waits are made, and each counts from zero: after the read address phase, after the page read, and after 0x10. If the line was low for L cycles, the wait ends normally when L <= TIMEOUT. When ready arrives in the same cycle as the limit, ready wins.
- R6: If the line is still low when the wait counter reaches TIMEOUT, the run stops. The error flag is set, err_code becomes 1, and no further bus cycle is issued.
- R7: If bit 3 or bit 4 of the status byte is 1, the run stops with the error flag set and err_code 2. The other six bits have no effect.
- R8: A run of N pages copies source pages S..S+N-1 to destination pages D..D+N-1 and gives one done pulse after the last page.
- R9: A start with a page count of 0 gives a done pulse in the next cycle and issues no bus cycle.
- R10: done is high for exactly one cycle. error and err_code keep their values until the next accepted start, which clears them.
- R11: A start pulse that arrives while a run is in progress is ignored.
- R12: The write strobe and the read strobe are never low at the same time. Data is driven whenever the write strobe is low. The command latch and the address latch are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a copy run |
| src_page | input | 8*ADDR_BYTES | First source page address |
| dst_page | input | 8*ADDR_BYTES | First destination page address |
| page_count | input | CNT_W | Number of pages to copy |
| done | output | 1 | One-cycle pulse when a run ends cleanly |
| error | output | 1 | Sticky failure flag |
| err_code | output | 2 | 0 none, 1 ready/busy timeout, 2 status failure |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the card |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte returned by the card |
| nand_rb_n | input | 1 | Ready/busy line, low while busy |

## Verification
The two events that can land in the same cycle are the synchronized ready edge and the wait counter reaching its limit. The bench card model holds ready/busy low for a set number of cycles after the read address phase and after the program confirm. It sweeps that length from two below the limit to two above it. At or below the limit the run must reach done. Above the limit it must stop with code 1 before any data-load command. A second sweep walks a single set bit through every position of the status byte, and only bits 3 and 4 may cause a failure.

// File: rtl/nand_copy_pkg.sv
package nand_copy_pkg;

   typedef enum logic [1:0] {
      BUS_CMD  = 2'd0,
      BUS_ADDR = 2'd1,
      BUS_WR   = 2'd2,
      BUS_RD   = 2'd3
   } bus_kind_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_STATUS  = 2'd2
   } err_code_e;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_CMD, S_RD_ADDR, S_RD_WAIT, S_RD_DATA, S_RD_WAIT2,
      S_PG_CMD, S_PG_ADDR, S_PG_DATA, S_PG_CONF, S_PG_WAIT,
      S_ST_CMD, S_ST_READ, S_NEXT
   } seq_st_e;

   localparam logic [7:0] OP_READ = 8'h00;
   localparam logic [7:0] OP_LOAD = 8'h80;
   localparam logic [7:0] OP_PROG = 8'h10;
   localparam logic [7:0] OP_STAT = 8'h70;

endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
   import nand_copy_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  bus_kind_e kind,
   input  logic [7:0] wbyte,
   output logic      ack,
   output logic [7:0] rbyte,
   output logic      cle,
   output logic      ale,
   output logic      we_n,
   output logic      re_n,
   output logic [7:0] dq_out,
   output logic      dq_oe,
   input  logic [7:0] dq_in
);

   logic ph;   // 1 while the strobe is low

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= 1'b0;
         ack    <= 1'b0;
         rbyte  <= '0;
         cle    <= 1'b0;
         ale    <= 1'b0;
         we_n   <= 1'b1;
         re_n   <= 1'b1;
         dq_out <= '0;
         dq_oe  <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (!ph) begin
            if (req) begin
               ph     <= 1'b1;
               cle    <= (kind == BUS_CMD);
               ale    <= (kind == BUS_ADDR);
               we_n   <= (kind == BUS_RD);
               re_n   <= (kind != BUS_RD);
               dq_oe  <= (kind != BUS_RD);
               dq_out <= wbyte;
            end
         end else begin
            ph    <= 1'b0;
            cle   <= 1'b0;
            ale   <= 1'b0;
            we_n  <= 1'b1;
            re_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b1;
            if (!re_n) rbyte <= dq_in;
         end
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n)); // R12
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R12
   AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> dq_oe); // R12
   AST_REQ_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> !ph && !ack); // R12

endmodule

// File: rtl/nand_rb_waiter.sv
module nand_rb_waiter #(
   parameter int TIMEOUT     = 16'hF000,
   parameter int BLANK       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n,
   input  logic arm,
   output logic ok,
   output logic tmo
);

   localparam int TMO_W = $clog2(TIMEOUT + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BLANK >= TIMEOUT) begin : g_bad_blank
         $error("BLANK must be below TIMEOUT");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [TMO_W-1:0]       cnt;
   logic                   ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rb_n};
   end
   assign ready = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!arm)                      cnt <= '0;
      else if (cnt != TMO_W'(TIMEOUT))    cnt <= cnt + 1'b1;
   end

   assign ok  = arm && ready && (cnt >= TMO_W'(BLANK));
   assign tmo = arm && !ok && (cnt == TMO_W'(TIMEOUT));

   AST_CNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm) |-> cnt == '0); // R5

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
   parameter int DEPTH = 528,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] idx,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   generate
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("page buffer index too narrow");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/nand_copy_seq.sv
module nand_copy_seq
   import nand_copy_pkg::*;
#(
   parameter int         ADDR_BYTES = 3,
   parameter int         PAGE_BYTES = 528,
   parameter int         CNT_W      = 16,
   parameter int         IDX_W      = 10,
   parameter logic [7:0] STAT_MASK  = 8'h18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [8*ADDR_BYTES-1:0] src_page,
   input  logic [8*ADDR_BYTES-1:0] dst_page,
   input  logic [CNT_W-1:0]        page_count,
   output logic                    bus_req,
   output bus_kind_e               bus_kind,
   output logic [7:0]              bus_wbyte,
   input  logic                    bus_ack,
   input  logic [7:0]              bus_rbyte,
   output logic                    buf_we,
   output logic [IDX_W-1:0]        buf_idx,
   input  logic [7:0]              buf_rdata,
   output logic                    wait_arm,
   input  logic                    wait_ok,
   input  logic                    wait_tmo,
   output logic                    done,
   output logic                    error,
   output logic [1:0]              err_code
);

   localparam int AW = 8 * ADDR_BYTES;
   localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(ADDR_BYTES - 1);
   localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(PAGE_BYTES - 1);

   seq_st_e          st;
   logic             launched;
   logic [IDX_W-1:0] idx;
   logic [AW-1:0]    src_q, dst_q;
   logic [CNT_W-1:0] remain;
   logic             is_bus;
   logic [AW-1:0]    src_sh, dst_sh;

   assign src_sh = src_q >> {idx, 3'b000};
   assign dst_sh = dst_q >> {idx, 3'b000};

   always_comb begin
      is_bus    = 1'b1;
      bus_kind  = BUS_CMD;
      bus_wbyte = OP_READ;
      unique case (st)
         S_RD_CMD:  bus_wbyte = OP_READ;
         S_RD_ADDR: begin bus_kind = BUS_ADDR; bus_wbyte = src_sh[7:0]; end
         S_RD_DATA: bus_kind = BUS_RD;
         S_PG_CMD:  bus_wbyte = OP_LOAD;
         S_PG_ADDR: begin bus_kind = BUS_ADDR; bus_wbyte = dst_sh[7:0]; end
         S_PG_DATA: begin bus_kind = BUS_WR; bus_wbyte = buf_rdata; end
         S_PG_CONF: bus_wbyte = OP_PROG;
         S_ST_CMD:  bus_wbyte = OP_STAT;
         S_ST_READ: bus_kind = BUS_RD;
         default:   is_bus = 1'b0;
      endcase
   end

   assign bus_req  = is_bus && !launched;
   assign buf_we   = bus_ack && (st == S_RD_DATA);
   assign buf_idx  = idx;
   assign wait_arm = (st == S_RD_WAIT) || (st == S_RD_WAIT2) || (st == S_PG_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         launched <= 1'b0;
         idx      <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         remain   <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
         err_code <= ERR_NONE;
      end else begin
         done <= 1'b0;
         if (bus_req)      launched <= 1'b1;
         else if (bus_ack) launched <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               error    <= 1'b0;
               err_code <= ERR_NONE;
               if (page_count == '0) begin
                  done <= 1'b1;
               end else begin
                  src_q  <= src_page;
                  dst_q  <= dst_page;
                  remain <= page_count;
                  idx    <= '0;
                  st     <= S_RD_CMD;
               end
            end
            S_RD_CMD: if (bus_ack) st <= S_RD_ADDR;
            S_RD_ADDR: if (bus_ack) begin
               if (idx == LAST_ADDR) begin idx <= '0; st <= S_RD_WAIT; end
               else idx <= idx + 1'b1;
            end
            S_RD_WAIT: begin
               if (wait_ok) st <= S_RD_DATA;
               else if (wait_tmo) begin st <= S_IDLE; error <= 1'b1; err_code <= ERR_TIMEOUT; end
            end
            S_RD_DATA: if (bus_ack) begin
               if (idx == LAST_DATA) begin idx <= '0; st <= S_RD_WAIT2; end
               else idx <= idx + 1'b1;
            end
            S_RD_WAIT2: begin
               if (wait_ok) st <= S_PG_CMD;
               else if (wait_tmo) begin st <= S_IDLE; error <= 1'b1; err_code <= ERR_TIMEOUT; end
            end
            S_PG_CMD: if (bus_ack) st <= S_PG_ADDR;
            S_PG_ADDR: if (bus_ack) begin
               if (idx == LAST_ADDR) begin idx <= '0; st <= S_PG_DATA; end
               else idx <= idx + 1'b1;
            end
            S_PG_DATA: if (bus_ack) begin
               if (idx == LAST_DATA) begin idx <= '0; st <= S_PG_CONF; end
               else idx <= idx + 1'b1;
            end
            S_PG_CONF: if (bus_ack) st <= S_PG_WAIT;
            S_PG_WAIT: begin
               if (wait_ok) st <= S_ST_CMD;
               else if (wait_tmo) begin st <= S_IDLE; error <= 1'b1; err_code <= ERR_TIMEOUT; end
            end
            S_ST_CMD: if (bus_ack) st <= S_ST_READ;
            S_ST_READ: if (bus_ack) begin
               if ((bus_rbyte & STAT_MASK) != 8'h00) begin
                  st <= S_IDLE; error <= 1'b1; err_code <= ERR_STATUS;
               end else st <= S_NEXT;
            end
            S_NEXT: begin
               src_q  <= src_q + 1'b1;
               dst_q  <= dst_q + 1'b1;
               remain <= remain - 1'b1;
               if (remain == CNT_W'(1)) begin st <= S_IDLE; done <= 1'b1; end
               else st <= S_RD_CMD;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |=> error && $stable(err_code)); // R10
   AST_CODE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      error == (err_code != ERR_NONE)); // R6
   AST_TMO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      wait_tmo |=> error && err_code == ERR_TIMEOUT && !bus_req); // R6
   AST_STAT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ST_READ && bus_ack && (bus_rbyte & STAT_MASK) != 8'h00)
      |=> error && err_code == ERR_STATUS); // R7

endmodule

// File: rtl/nand_page_copier.sv
module nand_page_copier
   import nand_copy_pkg::*;
#(
   parameter int ADDR_BYTES  = 3,
   parameter int PAGE_BYTES  = 528,
   parameter int CNT_W       = 16,
   parameter int TIMEOUT     = 16'hF000,
   parameter int BLANK       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [8*ADDR_BYTES-1:0] src_page,
   input  logic [8*ADDR_BYTES-1:0] dst_page,
   input  logic [CNT_W-1:0]        page_count,
   output logic                    done,
   output logic                    error,
   output logic [1:0]              err_code,
   output logic                    nand_cle,
   output logic                    nand_ale,
   output logic                    nand_we_n,
   output logic                    nand_re_n,
   output logic [7:0]              nand_dq_out,
   output logic                    nand_dq_oe,
   input  logic [7:0]              nand_dq_in,
   input  logic                    nand_rb_n
);

   localparam int MAXN  = (PAGE_BYTES > ADDR_BYTES) ? PAGE_BYTES : ADDR_BYTES;
   localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_ab
         $error("ADDR_BYTES out of range");
      end
      if (PAGE_BYTES < 2) begin : g_bad_pb
         $error("PAGE_BYTES must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cw
         $error("CNT_W must be positive");
      end
   endgenerate

   logic       bus_req, bus_ack, buf_we, wait_arm, wait_ok, wait_tmo;
   bus_kind_e  bus_kind;
   logic [7:0] bus_wbyte, bus_rbyte, buf_rdata;
   logic [IDX_W-1:0] buf_idx;

   nand_copy_seq #(
      .ADDR_BYTES(ADDR_BYTES), .PAGE_BYTES(PAGE_BYTES),
      .CNT_W(CNT_W), .IDX_W(IDX_W), .STAT_MASK(8'h18)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_page(src_page), .dst_page(dst_page), .page_count(page_count),
      .bus_req(bus_req), .bus_kind(bus_kind), .bus_wbyte(bus_wbyte),
      .bus_ack(bus_ack), .bus_rbyte(bus_rbyte),
      .buf_we(buf_we), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
      .wait_arm(wait_arm), .wait_ok(wait_ok), .wait_tmo(wait_tmo),
      .done(done), .error(error), .err_code(err_code)
   );

   nand_bus_phy i_phy (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .kind(bus_kind),
      .wbyte(bus_wbyte), .ack(bus_ack), .rbyte(bus_rbyte),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_out(nand_dq_out), .dq_oe(nand_dq_oe), .dq_in(nand_dq_in)
   );

   nand_rb_waiter #(
      .TIMEOUT(TIMEOUT), .BLANK(BLANK), .SYNC_STAGES(SYNC_STAGES)
   ) i_wait (
      .clk(clk), .rst_n(rst_n), .rb_n(nand_rb_n), .arm(wait_arm),
      .ok(wait_ok), .tmo(wait_tmo)
   );

   nand_page_buf #(.DEPTH(PAGE_BYTES), .AW(IDX_W)) i_buf (
      .clk(clk), .we(buf_we), .idx(buf_idx), .wdata(bus_rbyte), .rdata(buf_rdata)
   );

endmodule

// File: tb/test_nand_page_copier.sv
`timescale 1ns/1ps
module test_nand_page_copier;

   localparam int PB  = 8;
   localparam int AB  = 2;
   localparam int TMO = 64;
   localparam int NP  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [15:0] src = '0, dst = '0;
   logic [7:0]  cnt = '0;
   logic done, error;
   logic [1:0] err_code;
   logic cle, ale, we_n, re_n, dq_oe;
   logic [7:0] dq_out;
   logic [7:0] dq_in = '0;
   logic rb_n = 1'b1;

   always #2.5 clk = ~clk;

   nand_page_copier #(
      .ADDR_BYTES(AB), .PAGE_BYTES(PB), .CNT_W(8), .TIMEOUT(TMO),
      .BLANK(2), .SYNC_STAGES(2)
   ) i_nand_page_copier (
      .clk(clk), .rst_n(rst_n), .start(start), .src_page(src), .dst_page(dst),
      .page_count(cnt), .done(done), .error(error), .err_code(err_code),
      .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
      .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
      .nand_rb_n(rb_n)
   );

   int n_checks = 0, n_fail = 0;
   int cycles = 0;

   task automatic chk(input string r, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   // ---------------- card model ----------------
   logic [7:0] mem [NP*PB];
   logic [7:0] last_cmd = 8'hFF;
   logic [7:0] status_val = 8'h00;
   int addr_cnt = 0, addr_acc = 0, page_sel = 0, rd_ptr = 0, wr_ptr = 0;
   int busy_cnt = 0, rd_busy = 10, pg_busy = 10;
   int cmd_log [64];
   int src_log [16];
   int dst_log [16];
   int cmd_n = 0, src_n = 0, dst_n = 0, wr_n = 0, strobe_bad = 0, done_n = 0;

   function automatic logic [7:0] pat(input int p, input int i);
      return 8'((p * 37 + i * 11 + 5) & 255);
   endfunction

   task automatic init_card();
      for (int p = 0; p < NP; p++)
         for (int i = 0; i < PB; i++) mem[p*PB+i] = pat(p, i);
      cmd_n = 0; src_n = 0; dst_n = 0; wr_n = 0; done_n = 0;
   endtask

   always @(negedge clk) begin
      cycles++;
      if (done) done_n++;
      if (!we_n && !re_n) strobe_bad++;
      if (!we_n && !dq_oe) strobe_bad++;
      if (cle && ale) strobe_bad++;
      if (busy_cnt > 0) begin
         busy_cnt--;
         if (busy_cnt == 0) rb_n = 1'b1;
      end
      if (!we_n) begin
         if (cle) begin
            if (cmd_n < 64) cmd_log[cmd_n] = int'(dq_out);
            cmd_n++;
            last_cmd = dq_out;
            addr_cnt = 0; addr_acc = 0;
            if (dq_out == 8'h10 && pg_busy > 0) begin busy_cnt = pg_busy; rb_n = 1'b0; end
         end else if (ale) begin
            addr_acc = addr_acc | (int'(dq_out) << (8*addr_cnt));
            addr_cnt++;
            if (addr_cnt == AB) begin
               page_sel = addr_acc % NP; rd_ptr = 0; wr_ptr = 0;
               if (last_cmd == 8'h00) begin
                  if (src_n < 16) src_log[src_n] = addr_acc;
                  src_n++;
                  if (rd_busy > 0) begin busy_cnt = rd_busy; rb_n = 1'b0; end
               end else begin
                  if (dst_n < 16) dst_log[dst_n] = addr_acc;
                  dst_n++;
               end
            end
         end else begin
            if (wr_ptr < PB) mem[page_sel*PB+wr_ptr] = dq_out;
            wr_ptr++; wr_n++;
         end
      end
      if (!re_n) begin
         if (last_cmd == 8'h70) dq_in = status_val;
         else dq_in = mem[page_sel*PB + (rd_ptr % PB)];
         rd_ptr++;
      end
   end

   // watchdog
   initial begin
      wait (cycles > 150000);
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   task automatic run_copy(input int s, input int d, input int c, output int code);
      @(negedge clk);
      src = 16'(s); dst = 16'(d); cnt = 8'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      code = -1;
      for (int k = 0; k < 20000; k++) begin
         if (done) begin code = 0; break; end
         if (error) begin code = int'(err_code); break; end
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   function automatic int has_cmd(input int v);
      for (int k = 0; k < 64; k++) if (k < cmd_n && cmd_log[k] == v) return 1;
      return 0;
   endfunction

   int code;

   initial begin
      init_card();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 done", int'(done), 0);
      chk("R1 error", int'(error), 0);
      chk("R1 code", int'(err_code), 0);
      chk("R1 strobes", int'({we_n, re_n}), 3);
      chk("R1 latches", int'({cle, ale}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: zero count, done in the next cycle, no bus activity
      src = 16'h0001; dst = 16'h0002; cnt = 8'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R9 done next cycle", int'(done), 1);
      @(negedge clk);
      chk("R10 done one cycle", int'(done), 0);
      repeat (10) @(negedge clk);
      chk("R9 no bus cycle", cmd_n, 0);

      // R2 R3 R4 R5: single page
      init_card();
      run_copy(16'h0203, 16'h0A09, 1, code);
      chk("R5 single page completes", code, 0);
      chk("R2 command count", cmd_n, 4);
      chk("R2 cmd0", cmd_log[0], 8'h00);
      chk("R2 cmd1", cmd_log[1], 8'h80);
      chk("R2 cmd2", cmd_log[2], 8'h10);
      chk("R2 cmd3", cmd_log[3], 8'h70);
      chk("R3 source address", src_log[0], 16'h0203);
      chk("R3 dest address", dst_log[0], 16'h0A09);
      chk("R4 bytes written", wr_n, PB);
      for (int i = 0; i < PB; i++) chk("R4 copied byte", int'(mem[9*PB+i]), int'(pat(3, i)));
      chk("R10 one done", done_n, 1);

      // R8: three pages
      init_card();
      run_copy(16'h0105, 16'h010A, 3, code);
      chk("R8 completes", code, 0);
      chk("R8 done pulses", done_n, 1);
      chk("R8 command count", cmd_n, 12);
      for (int p = 0; p < 3; p++) begin
         chk("R8 source step", src_log[p], 16'h0105 + p);
         chk("R8 dest step", dst_log[p], 16'h010A + p);
         for (int i = 0; i < PB; i++)
            chk("R8 page data", int'(mem[(10+p)*PB+i]), int'(pat(5+p, i)));
      end

      // R7: walk one set bit through the status byte
      for (int b = 0; b < 8; b++) begin
         init_card();
         status_val = 8'(1 << b);
         run_copy(16'h0001, 16'h0004, 1, code);
         chk("R7 status bit outcome", code, (b == 3 || b == 4) ? 2 : 0);
         chk("R7 error flag", int'(error), (b == 3 || b == 4) ? 1 : 0);
      end
      status_val = 8'h00;

      // R5 R6: busy length around the limit
      for (int l = TMO - 2; l <= TMO + 2; l++) begin
         init_card();
         rd_busy = l; pg_busy = l;
         run_copy(16'h0002, 16'h0006, 1, code);
         chk("R5 R6 busy sweep code", code, (l <= TMO) ? 0 : 1);
         if (l > TMO) begin
            chk("R6 no load after timeout", has_cmd(8'h80), 0);
            repeat (TMO) @(negedge clk);
            chk("R10 error held", int'(error), 1);
            chk("R10 code held", int'(err_code), 1);
         end
      end

      // R6: stuck only after program confirm
      init_card();
      rd_busy = 10; pg_busy = 1000;
      run_copy(16'h0002, 16'h0006, 1, code);
      chk("R6 program wait timeout", code, 1);
      chk("R6 no status cmd", has_cmd(8'h70), 0);
      repeat (1000) @(negedge clk);
      pg_busy = 10;

      // R10: new start clears error
      init_card();
      run_copy(16'h0003, 16'h0007, 1, code);
      chk("R10 error cleared", int'(error), 0);
      chk("R10 clean run", code, 0);

      // R11: start during a run is ignored
      init_card();
      @(negedge clk);
      src = 16'h0001; dst = 16'h0008; cnt = 8'd1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      src = 16'h0004; dst = 16'h000C; cnt = 8'd5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 5000; k++) begin
         if (done || error) break;
         @(negedge clk);
      end
      repeat (200) @(negedge clk);
      chk("R11 single load command", cmd_n, 4);
      chk("R11 one done", done_n, 1);
      chk("R11 first dest copied", int'(mem[8*PB+2]), int'(pat(1, 2)));

      // R12
      chk("R12 strobe rules", strobe_bad, 0);

      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

endmodule